// File: doc/BRIEF.md
# Lockable Two-Stage Watchdog Timer

This block is a watchdog that software reaches through a simple register port: an address, write data, a write strobe and combinational read data. A 32-bit counter counts down by one on each clock cycle in which the counter clock enable is high, while the run bit is set. When the counter is at zero on such a cycle, the first expiry raises an interrupt and reloads the counter from the load value. If the interrupt is still pending at the next expiry and reset generation is enabled, the block raises a reset request. That request stays high until the block itself is reset.

Software services the watchdog by writing the interrupt clear register. This clears the pending interrupt and reloads the counter in one step. Every register except the lock register ignores writes until software writes the unlock key to the lock register. Writing any other value to the lock register locks the block again.

Top module: `twostage_wdog`

## Requirements
- R1: After reset, the load, count, control and status registers read zero, the lock register reads 1 (locked), and both irq and rst_req are low.
- R2: Writing 0x1ACCE551 to offset 0xC00 unlocks the block, and the lock register then reads 0. Writing any other value to 0xC00 locks the block, and the lock register then reads 1.
- R3: While locked, writes to load (0x000), control (0x008) and interrupt clear (0x00C) have no effect. Reads of every register are always allowed.
- R4: With control bit 0 (run) set and cnt_en high, the count at 0x004 drops by one per clock. With cnt_en low, the count holds.
- R5: A counting cycle that finds the count at zero is an expiry. At the first expiry, irq rises, the status register at 0x014 reads 1, and the count reloads from the load register.
- R6: An expiry while the interrupt is already pending asserts rst_req if control bit 1 is set. rst_req then stays high until rst_n. With bit 1 clear, the same expiry leaves rst_req low.
- R7: An unlocked write to 0x00C clears the pending interrupt and reloads the count from the load register.
- R8: An unlocked write to load while run is set also places the written value in the count in the same cycle.
- R9: Clearing the run bit drops irq at once and freezes the count.
- R10: Control reads return zero in bits 31:2. Reads of offsets with no register, and of 0x00C, return zero.
- R11: A load of 0xFFFFFFFF is accepted, and one counting cycle later the count is 0xFFFFFFFE.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cnt_en | input | 1 | Counter clock enable, one count per high cycle |
| addr | input | 12 | Register byte offset |
| wdata | input | 32 | Write data |
| we | input | 1 | Write strobe |
| rdata | output | 32 | Read data for addr, combinational |
| irq | output | 1 | First-stage interrupt |
| rst_req | output | 1 | Sticky reset request |

## Verification
Read data is combinational, so the bench samples it one time step after it sets addr, within the same cycle. A register write takes effect at the clock edge that samples it, and the bench reads it back at the next falling edge. Each counting cycle changes the count, irq or rst_req at its own rising edge. With a load of N, the first expiry therefore lands on the N+1th counting cycle after a reload. The bench raises cnt_en for an exact number of rising edges, and every expected count and flag is computed from that number.

// File: rtl/wdg_pkg.sv
// Package: shared register offsets, widths and unlock key for the watchdog.
// Assumes byte offsets on a 12-bit address and 32-bit data.
package wdg_pkg;
    localparam int unsigned ADDR_W = 12;
    localparam int unsigned DATA_W = 32;
    localparam logic [ADDR_W-1:0] OFF_LOAD  = 12'h000;
    localparam logic [ADDR_W-1:0] OFF_COUNT = 12'h004;
    localparam logic [ADDR_W-1:0] OFF_CTRL  = 12'h008;
    localparam logic [ADDR_W-1:0] OFF_CLR   = 12'h00C;
    localparam logic [ADDR_W-1:0] OFF_STAT  = 12'h014;
    localparam logic [ADDR_W-1:0] OFF_LOCK  = 12'hC00;
    localparam logic [DATA_W-1:0] UNLOCK_KEY = 32'h1ACCE551;

    typedef struct packed {
        logic rst_en;
        logic run;
    } ctrl_t;
endpackage

// File: rtl/wdg_regs.sv
// Module: register file with key lock. It holds load, control and lock state,
// turns unlocked writes into reload/clear commands for the counter, and
// drives the combinational read mux. Assumes one write per cycle at most.
module wdg_regs
    import wdg_pkg::*;
#(
    parameter int unsigned AW = ADDR_W,
    parameter int unsigned DW = DATA_W
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic [AW-1:0] addr,
    input  logic [DW-1:0] wdata,
    input  logic          we,
    input  logic [DW-1:0] count,
    input  logic          pend,
    output logic [DW-1:0] load_q,
    output ctrl_t         ctrl_q,
    output logic          reload,
    output logic [DW-1:0] reload_val,
    output logic          clr,
    output logic [DW-1:0] rdata
);
    logic locked_q;
    logic wr_ok;
    logic wr_load, wr_ctrl, wr_clr, wr_lock;

    // Decode writes; only the lock register accepts writes while locked.
    always_comb begin
        wr_ok   = we && !locked_q;
        wr_load = wr_ok && (addr == AW'(OFF_LOAD));
        wr_ctrl = wr_ok && (addr == AW'(OFF_CTRL));
        wr_clr  = wr_ok && (addr == AW'(OFF_CLR));
        wr_lock = we && (addr == AW'(OFF_LOCK));
    end

    // Lock state: key unlocks, any other value locks.
    always_ff @(posedge clk) begin
        if (!rst_n)       locked_q <= 1'b1;
        else if (wr_lock) locked_q <= (wdata != UNLOCK_KEY);
    end

    // Load and control registers.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            load_q <= '0;
            ctrl_q <= '0;
        end else begin
            if (wr_load) load_q <= wdata;
            if (wr_ctrl) ctrl_q <= ctrl_t'(wdata[1:0]);
        end
    end

    // Counter commands: clear reloads from load; load write reloads while running.
    always_comb begin
        clr        = wr_clr;
        reload     = wr_clr || (wr_load && ctrl_q.run);
        reload_val = wr_load ? wdata : load_q;
    end

    // Read mux; reserved bits and unmapped offsets return zero.
    always_comb begin
        unique case (addr)
            AW'(OFF_LOAD):  rdata = load_q;
            AW'(OFF_COUNT): rdata = count;
            AW'(OFF_CTRL):  rdata = {{(DW-2){1'b0}}, ctrl_q};
            AW'(OFF_STAT):  rdata = {{(DW-1){1'b0}}, pend && ctrl_q.run};
            AW'(OFF_LOCK):  rdata = {{(DW-1){1'b0}}, locked_q};
            default:        rdata = '0;
        endcase
    end

    AST_LOCKED_LOAD_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (locked_q && we && addr == AW'(OFF_LOAD)) |=> $stable(load_q)); // R3
    AST_LOCKED_CTRL_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (locked_q && we && addr == AW'(OFF_CTRL)) |=> $stable(ctrl_q)); // R3
endmodule

// File: rtl/wdg_counter.sv
// Module: down-counter with two-stage expiry. The first expiry sets the
// pending flag and reloads; an expiry while pending sets a sticky reset
// request when enabled. Assumes reload/clr come from the register file.
module wdg_counter #(
    parameter int unsigned DW = 32
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          run,
    input  logic          rst_en,
    input  logic          tick,
    input  logic          reload,
    input  logic [DW-1:0] reload_val,
    input  logic          clr,
    input  logic [DW-1:0] load_q,
    output logic [DW-1:0] count,
    output logic          pend,
    output logic          rst_req
);
    logic step;
    logic expire;

    // Qualify a counting cycle and detect expiry; software reload wins.
    always_comb begin
        step   = run && tick && !reload;
        expire = step && (count == '0);
    end

    // Count register: reload, wrap to load at expiry, else decrement.
    always_ff @(posedge clk) begin
        if (!rst_n)      count <= '0;
        else if (reload) count <= reload_val;
        else if (expire) count <= load_q;
        else if (step)   count <= count - 1'b1;
    end

    // First-stage pending flag: cleared by service or stopping.
    always_ff @(posedge clk) begin
        if (!rst_n)              pend <= 1'b0;
        else if (clr || !run)    pend <= 1'b0;
        else if (expire)         pend <= 1'b1;
    end

    // Second-stage reset request, held until block reset.
    always_ff @(posedge clk) begin
        if (!rst_n)                         rst_req <= 1'b0;
        else if (expire && pend && rst_en)  rst_req <= 1'b1;
    end

    AST_RST_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
        rst_req |=> rst_req); // R6
    AST_RST_AFTER_PEND: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(rst_req) |-> $past(pend)); // R6
    AST_FROZEN_WHEN_STOPPED: assert property (@(posedge clk) disable iff (!rst_n)
        (!run && !reload) |=> $stable(count)); // R9
    AST_CLR_DROPS_PEND: assert property (@(posedge clk) disable iff (!rst_n)
        clr |=> !pend); // R7
    AST_HOLD_NO_TICK: assert property (@(posedge clk) disable iff (!rst_n)
        (!tick && !reload) |=> $stable(count)); // R4
endmodule

// File: rtl/twostage_wdog.sv
// Module: top of the lockable two-stage watchdog. It ties the register file to
// the counter. Assumes cnt_en is synchronous to clk.
module twostage_wdog
    import wdg_pkg::*;
#(
    parameter int unsigned AW = ADDR_W,
    parameter int unsigned DW = DATA_W
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          cnt_en,
    input  logic [AW-1:0] addr,
    input  logic [DW-1:0] wdata,
    input  logic          we,
    output logic [DW-1:0] rdata,
    output logic          irq,
    output logic          rst_req
);
    logic [DW-1:0] load_q, count, reload_val;
    ctrl_t         ctrl_q;
    logic          reload, clr, pend;

    wdg_regs #(.AW(AW), .DW(DW)) u_regs (
        .clk(clk), .rst_n(rst_n), .addr(addr), .wdata(wdata), .we(we),
        .count(count), .pend(pend), .load_q(load_q), .ctrl_q(ctrl_q),
        .reload(reload), .reload_val(reload_val), .clr(clr), .rdata(rdata)
    );

    wdg_counter #(.DW(DW)) u_cnt (
        .clk(clk), .rst_n(rst_n), .run(ctrl_q.run), .rst_en(ctrl_q.rst_en),
        .tick(cnt_en), .reload(reload), .reload_val(reload_val), .clr(clr),
        .load_q(load_q), .count(count), .pend(pend), .rst_req(rst_req)
    );

    // Interrupt output drops as soon as the run bit is cleared.
    always_comb irq = pend && ctrl_q.run;

    AST_IRQ_NEEDS_RUN: assert property (@(posedge clk) disable iff (!rst_n)
        irq |-> ctrl_q.run); // R9
endmodule

// File: tb/tb_twostage_wdog.sv
module tb_twostage_wdog;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cnt_en = 1'b0;
    logic [11:0] addr = '0;
    logic [31:0] wdata = '0;
    logic        we = 1'b0;
    logic [31:0] rdata;
    logic        irq, rst_req;
    int n_run = 0;
    int n_fail = 0;
    bit done = 0;

    localparam logic [31:0] KEY = 32'h1ACCE551;

    twostage_wdog dut (.clk(clk), .rst_n(rst_n), .cnt_en(cnt_en), .addr(addr),
        .wdata(wdata), .we(we), .rdata(rdata), .irq(irq), .rst_req(rst_req));

    always #5 clk = ~clk;

    task automatic check(string req, logic [31:0] act, logic [31:0] exp);
        n_run++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic do_reset();
        @(negedge clk); rst_n = 0; we = 0; cnt_en = 0;
        @(negedge clk); @(negedge clk); rst_n = 1;
    endtask

    task automatic wr(logic [11:0] a, logic [31:0] d);
        @(negedge clk); addr = a; wdata = d; we = 1;
        @(negedge clk); we = 0;
    endtask

    task automatic rd(logic [11:0] a, output logic [31:0] d);
        addr = a; #1; d = rdata;
    endtask

    task automatic ticks(int n);
        @(negedge clk); cnt_en = 1;
        repeat (n) @(posedge clk);
        @(negedge clk); cnt_en = 0;
    endtask

    // unlock, load n, service, run with ctrl value
    task automatic arm(logic [31:0] n, logic [31:0] c);
        wr(12'hC00, KEY); wr(12'h000, n); wr(12'h00C, 1); wr(12'h008, c);
    endtask

    task automatic t_reset_state();
        logic [31:0] d;
        do_reset();
        rd(12'h000, d); check("R1 load", d, 0);
        rd(12'h004, d); check("R1 count", d, 0);
        rd(12'h008, d); check("R1 ctrl", d, 0);
        rd(12'h014, d); check("R1 stat", d, 0);
        rd(12'hC00, d); check("R1 lock", d, 1);
        check("R1 irq/rst", {irq, rst_req}, 0);
    endtask

    task automatic t_lock();
        logic [31:0] d;
        do_reset();
        wr(12'h000, 7); wr(12'h008, 3);
        rd(12'h000, d); check("R3 load locked", d, 0);
        rd(12'h008, d); check("R3 ctrl locked", d, 0);
        wr(12'hC00, KEY); rd(12'hC00, d); check("R2 unlock", d, 0);
        wr(12'hC00, 32'h1ACCE550); rd(12'hC00, d); check("R2 relock", d, 1);
    endtask

    task automatic t_count();
        logic [31:0] d;
        do_reset(); arm(5, 1);
        rd(12'h004, d); check("R7 reload", d, 5);
        ticks(3); rd(12'h004, d); check("R4 dec", d, 2);
        repeat (3) @(negedge clk); rd(12'h004, d); check("R4 hold", d, 2);
        rd(12'h008, d); check("R10 ctrl", d, 1);
        wr(12'h008, 32'hFFFF_FFFF); rd(12'h008, d); check("R10 ctrl hi", d, 3);
        rd(12'h00C, d); check("R10 clr reads 0", d, 0);
        rd(12'h100, d); check("R10 unmapped", d, 0);
    endtask

    task automatic t_two_stage(bit rst_en);
        logic [31:0] d;
        do_reset(); arm(5, {30'b0, rst_en, 1'b1});
        ticks(5); check("R5 no early irq", irq, 0);
        ticks(1); check("R5 irq", irq, 1);
        rd(12'h014, d); check("R5 stat", d, 1);
        rd(12'h004, d); check("R5 reload", d, 5);
        ticks(5); check("R6 no early rst", rst_req, 0);
        ticks(1); check(rst_en ? "R6 rst" : "R6 rst disabled", rst_req, rst_en);
        if (rst_en) begin
            wr(12'h00C, 1); wr(12'h008, 0);
            check("R6 sticky", rst_req, 1);
        end
    endtask

    task automatic t_service();
        logic [31:0] d;
        do_reset(); arm(4, 3);
        ticks(5); check("R5 irq pre", irq, 1);
        ticks(2);
        wr(12'h00C, 1); check("R7 irq cleared", irq, 0);
        rd(12'h004, d); check("R7 reload", d, 4);
        ticks(5); check("R7 first again", {irq, rst_req}, 2'b10);
        wr(12'hC00, 0); wr(12'h00C, 1);
        check("R3 clr locked", irq, 1);
        wr(12'hC00, KEY); wr(12'h008, 0);
        check("R9 irq drop", irq, 0);
        rd(12'h004, d);
        ticks(20);
        begin logic [31:0] e; rd(12'h004, e); check("R9 frozen", e, d); end
        check("R9 no rst", rst_req, 0);
    endtask

    task automatic t_load_live();
        logic [31:0] d;
        do_reset(); arm(10, 1);
        ticks(2);
        wr(12'h000, 32'hFFFF_FFFF); rd(12'h004, d); check("R8 live load", d, 32'hFFFF_FFFF);
        ticks(1); rd(12'h004, d); check("R11 max", d, 32'hFFFF_FFFE);
    endtask

    initial begin
        t_reset_state();
        t_lock();
        t_count();
        t_two_stage(1'b1);
        t_two_stage(1'b0);
        t_service();
        t_load_live();
        done = 1;
    end

    initial begin
        fork
            wait (done);
            begin
                repeat (100000) @(posedge clk);
                n_run++; n_fail++;
                $display("FAIL watchdog: actual hung expected done");
            end
        join_any
        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end
endmodule